// File: doc/BRIEF.md
# Privileged Status and Timer Control

This block holds the privileged status word of a processor core and derives from it whether general registers currently operate 32 or 64 bits wide. Software writes a new status value through a single write port. Each write is filtered before it is stored. Bits that are reserved as zero are dropped. The two 64-bit enable bits are dropped when the build has no 64-bit support. The floating-point enable bit is dropped when the build has no floating-point support.

The active width comes from the supervisor bit. In supervisor mode the supervisor 64-bit enable decides the width; otherwise the user 64-bit enable decides it. The width is held in a two-state machine. `WID_32` moves to `WID_64` on the GROW transition, when a status write selects 64 bits. `WID_64` moves to `WID_32` on the SHRINK transition, when a status write selects 32 bits. Any other write keeps the current state.

Alongside the status word, a free-running counter advances once for each retired instruction and is compared with a compare register. A match raises a sticky timer bit in the pending-interrupt vector. Trap entry and interrupt dispatch belong to other blocks.

Top module: `stat_timer_ctl`

## Requirements
- R1: After reset the status word has only the supervisor bit (bit 3) and the supervisor 64-bit enable (bit 2) set. The supervisor 64-bit enable is cleared when 64-bit support is absent. The width indication, counter, compare and pending vector are all zero, except that the width reads 64 when that enable is kept.
- R2: A status write stores its data at the next clock edge with every bit outside the defined set cleared. The defined bits are fp-enable bit 0, user 64-bit enable bit 1, supervisor 64-bit enable bit 2, supervisor bit 3, interrupt enable bit 4 and interrupt mask bits 15:8.
- R3: When the parameter EN64 is 0, bits 1 and 2 of every written status value are stored as zero.
- R4: When the parameter ENFP is 0, bit 0 of every written status value is stored as zero. `fp_on_o` always equals stored bit 0.
- R5: `xlen64_o` is 1 exactly when the stored status selects 64 bits. With bit 3 set, bit 2 decides; with bit 3 clear, bit 1 decides.
- R6: Each cycle with `retire` high and no counter write increments the counter by one, wrapping at its width. Without `retire` the counter holds.
- R7: When an increment happens and the counter value before it equals the compare value, bit TIMER_IRQ (default 7) of `irq_pend_o` is set at the same edge.
- R8: The timer pending bit stays set until a pending-clear write whose mask has bit TIMER_IRQ set, or until any compare write.
- R9: A counter write in the same cycle as `retire` loads the written value, suppresses the increment and suppresses the match check.
- R10: A timer match in the same cycle as a clear of the timer pending bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_we | input | 1 | Status write enable |
| stat_wdata | input | 32 | Status write data |
| cnt_we | input | 1 | Counter write enable |
| cnt_wdata | input | CNT_W | Counter write data |
| cmp_we | input | 1 | Compare write enable |
| cmp_wdata | input | CNT_W | Compare write data |
| retire | input | 1 | One instruction retired this cycle |
| pend_clr_we | input | 1 | Pending-clear write enable |
| pend_clr_mask | input | IRQ_W | Pending bits to clear |
| status_o | output | 32 | Stored status word |
| xlen64_o | output | 1 | 1 when 64-bit width is active |
| fp_on_o | output | 1 | Floating-point enable |
| count_o | output | CNT_W | Counter value |
| irq_pend_o | output | IRQ_W | Pending-interrupt vector |

## Verification
A wrong width state shows on `xlen64_o` one edge after the status write that should have moved it, while `status_o` already holds the correct selecting bits. A stale or leaked mask bit shows in `status_o` on the first check after the write. A counter that misses or doubles a step shows on `count_o` after the next retire. A wrong match ordering, meaning a compare made after the increment or a counter write that does not block the match, sets or fails to set the timer bit at the edge of the deciding retire. The sticky bit is then held long enough for the bench to see it.

// File: rtl/stctl_pkg.sv
package stctl_pkg;

    localparam int STAT_W = 32;

    // status bit positions
    localparam int B_FP  = 0;
    localparam int B_U64 = 1;
    localparam int B_S64 = 2;
    localparam int B_SUP = 3;
    localparam int B_IE  = 4;

    // bits that may hold a one when every feature is built in
    localparam logic [STAT_W-1:0] DEF_MASK = 32'h0000_FF1F;

    typedef enum logic {
        WID_32 = 1'b0,
        WID_64 = 1'b1
    } wid_e;

    function automatic logic [STAT_W-1:0] legal_mask(input bit en64, input bit enfp);
        logic [STAT_W-1:0] m;
        m = DEF_MASK;
        if (!en64) begin
            m[B_U64] = 1'b0;
            m[B_S64] = 1'b0;
        end
        if (!enfp) begin
            m[B_FP] = 1'b0;
        end
        return m;
    endfunction

endpackage

// File: rtl/stat_word.sv
module stat_word
    import stctl_pkg::*;
#(
    parameter bit EN64 = 1'b1,
    parameter bit ENFP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] stat_q,
    output logic [STAT_W-1:0] stat_nxt
);

    localparam logic [STAT_W-1:0] MASK    = legal_mask(EN64, ENFP);
    localparam logic [STAT_W-1:0] RST_VAL =
        ((STAT_W'(1) << B_SUP) | (STAT_W'(1) << B_S64)) & MASK;

    always_comb begin
        stat_nxt = we ? (wdata & MASK) : stat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= RST_VAL;
        end else begin
            stat_q <= stat_nxt;
        end
    end

endmodule

// File: rtl/width_fsm.sv
module width_fsm
    import stctl_pkg::*;
#(
    parameter bit EN64 = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_nxt,
    output logic              xlen64
);

    localparam wid_e RST_STATE = EN64 ? WID_64 : WID_32;

    wid_e state_q;
    wid_e state_d;
    logic sel64;

    always_comb begin
        sel64 = stat_nxt[B_SUP] ? stat_nxt[B_S64] : stat_nxt[B_U64];
        state_d = state_q;
        unique case (state_q)
            WID_32: if (sel64)  state_d = WID_64;   // GROW
            WID_64: if (!sel64) state_d = WID_32;   // SHRINK
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            WID_32: xlen64 = 1'b0;
            WID_64: xlen64 = 1'b1;
        endcase
    end

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int CNT_W     = 32,
    parameter int IRQ_W     = 8,
    parameter int TIMER_IRQ = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             retire,
    input  logic             pend_clr_we,
    input  logic [IRQ_W-1:0] pend_clr_mask,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic [IRQ_W-1:0] pend_q
);

    logic             bump;
    logic             hit;
    logic [IRQ_W-1:0] pend_d;

    always_comb begin
        bump   = retire && !cnt_we;
        hit    = bump && (cnt_q == cmp_q);
        pend_d = pend_q;
        if (pend_clr_we) pend_d = pend_d & ~pend_clr_mask;
        if (cmp_we)      pend_d[TIMER_IRQ] = 1'b0;
        if (hit)         pend_d[TIMER_IRQ] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cmp_q  <= '0;
            pend_q <= '0;
        end else begin
            if (cnt_we)      cnt_q <= cnt_wdata;
            else if (bump)   cnt_q <= cnt_q + 1'b1;
            if (cmp_we)      cmp_q <= cmp_wdata;
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/stat_timer_ctl.sv
module stat_timer_ctl
    import stctl_pkg::*;
#(
    parameter bit EN64      = 1'b1,
    parameter bit ENFP      = 1'b1,
    parameter int CNT_W     = 32,
    parameter int IRQ_W     = 8,
    parameter int TIMER_IRQ = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_we,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              cmp_we,
    input  logic [CNT_W-1:0]  cmp_wdata,
    input  logic              retire,
    input  logic              pend_clr_we,
    input  logic [IRQ_W-1:0]  pend_clr_mask,
    output logic [STAT_W-1:0] status_o,
    output logic              xlen64_o,
    output logic              fp_on_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [IRQ_W-1:0]  irq_pend_o
);

    logic [STAT_W-1:0] stat_nxt;
    logic [CNT_W-1:0]  cmp_q;

    stat_word #(.EN64(EN64), .ENFP(ENFP)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (stat_we),
        .wdata    (stat_wdata),
        .stat_q   (status_o),
        .stat_nxt (stat_nxt)
    );

    width_fsm #(.EN64(EN64)) u_wid (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_nxt (stat_nxt),
        .xlen64   (xlen64_o)
    );

    tick_timer #(.CNT_W(CNT_W), .IRQ_W(IRQ_W), .TIMER_IRQ(TIMER_IRQ)) u_tmr (
        .clk           (clk),
        .rst_n         (rst_n),
        .cnt_we        (cnt_we),
        .cnt_wdata     (cnt_wdata),
        .cmp_we        (cmp_we),
        .cmp_wdata     (cmp_wdata),
        .retire        (retire),
        .pend_clr_we   (pend_clr_we),
        .pend_clr_mask (pend_clr_mask),
        .cnt_q         (count_o),
        .cmp_q         (cmp_q),
        .pend_q        (irq_pend_o)
    );

    assign fp_on_o = status_o[B_FP];

endmodule

// File: rtl/stat_timer_ctl_chk.sv
module stat_timer_ctl_chk
    import stctl_pkg::*;
#(
    parameter bit EN64      = 1'b1,
    parameter bit ENFP      = 1'b1,
    parameter int CNT_W     = 32,
    parameter int IRQ_W     = 8,
    parameter int TIMER_IRQ = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_we,
    input logic [CNT_W-1:0]  cnt_wdata,
    input logic              cmp_we,
    input logic              retire,
    input logic              pend_clr_we,
    input logic [IRQ_W-1:0]  pend_clr_mask,
    input logic [STAT_W-1:0] status_o,
    input logic              xlen64_o,
    input logic              fp_on_o,
    input logic [CNT_W-1:0]  count_o,
    input logic [CNT_W-1:0]  cmp_q,
    input logic [IRQ_W-1:0]  irq_pend_o
);

    // R2
    zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & ~DEF_MASK) == '0);

    generate
        if (!EN64) begin : g_no64
            // R3
            no_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !status_o[B_U64] && !status_o[B_S64] && !xlen64_o);
        end
        if (!ENFP) begin : g_nofp
            // R4
            no_fp_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !fp_on_o);
        end
    endgenerate

    // R5
    width_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xlen64_o == (status_o[B_SUP] ? status_o[B_S64] : status_o[B_U64]));

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !cnt_we) |=> count_o == CNT_W'($past(count_o) + 1'b1));

    // R9
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> count_o == $past(cnt_wdata));

    // R7
    timer_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !cnt_we && count_o == cmp_q) |=> irq_pend_o[TIMER_IRQ]);

    // R8
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend_o[TIMER_IRQ] && !cmp_we && !(pend_clr_we && pend_clr_mask[TIMER_IRQ]))
        |=> irq_pend_o[TIMER_IRQ]);

endmodule

bind stat_timer_ctl stat_timer_ctl_chk #(
    .EN64(EN64), .ENFP(ENFP), .CNT_W(CNT_W), .IRQ_W(IRQ_W), .TIMER_IRQ(TIMER_IRQ)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cnt_we        (cnt_we),
    .cnt_wdata     (cnt_wdata),
    .cmp_we        (cmp_we),
    .retire        (retire),
    .pend_clr_we   (pend_clr_we),
    .pend_clr_mask (pend_clr_mask),
    .status_o      (status_o),
    .xlen64_o      (xlen64_o),
    .fp_on_o       (fp_on_o),
    .count_o       (count_o),
    .cmp_q         (cmp_q),
    .irq_pend_o    (irq_pend_o)
);

// File: tb/stat_timer_ctl_tb.sv
module stat_timer_ctl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 32;
    localparam int IRQ_W      = 8;
    localparam int NV         = 8;

    typedef struct packed {
        logic [31:0] wd;
        logic [31:0] full_s;
        logic        full_w;
        logic        full_f;
        logic [31:0] lite_s;
        logic        lite_w;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{32'hFFFF_FFFF, 32'h0000_FF1F, 1'b1, 1'b1, 32'h0000_FF18, 1'b0},
        '{32'h0000_0008, 32'h0000_0008, 1'b0, 1'b0, 32'h0000_0008, 1'b0},
        '{32'h0000_0002, 32'h0000_0002, 1'b1, 1'b0, 32'h0000_0000, 1'b0},
        '{32'h0000_0004, 32'h0000_0004, 1'b0, 1'b0, 32'h0000_0000, 1'b0},
        '{32'h0000_000C, 32'h0000_000C, 1'b1, 1'b0, 32'h0000_0008, 1'b0},
        '{32'h1234_5601, 32'h0000_5601, 1'b0, 1'b1, 32'h0000_5600, 1'b0},
        '{32'hA5A5_00FA, 32'h0000_001A, 1'b0, 1'b0, 32'h0000_0018, 1'b0},
        '{32'h0000_0016, 32'h0000_0016, 1'b1, 1'b0, 32'h0000_0010, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             stat_we = 1'b0;
    logic [31:0]      stat_wdata = '0;
    logic             cnt_we = 1'b0;
    logic [CNT_W-1:0] cnt_wdata = '0;
    logic             cmp_we = 1'b0;
    logic [CNT_W-1:0] cmp_wdata = '0;
    logic             retire = 1'b0;
    logic             pend_clr_we = 1'b0;
    logic [IRQ_W-1:0] pend_clr_mask = '0;

    logic [31:0]      st_f, st_l;
    logic             w_f, w_l, fp_f, fp_l;
    logic [CNT_W-1:0] cnt_f, cnt_l;
    logic [IRQ_W-1:0] pd_f, pd_l;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stat_timer_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .stat_we(stat_we), .stat_wdata(stat_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .retire(retire), .pend_clr_we(pend_clr_we), .pend_clr_mask(pend_clr_mask),
        .status_o(st_f), .xlen64_o(w_f), .fp_on_o(fp_f), .count_o(cnt_f), .irq_pend_o(pd_f)
    );

    stat_timer_ctl #(.EN64(1'b0), .ENFP(1'b0)) u_dut_lite (
        .clk(clk), .rst_n(rst_n), .stat_we(stat_we), .stat_wdata(stat_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .retire(retire), .pend_clr_we(pend_clr_we), .pend_clr_mask(pend_clr_mask),
        .status_o(st_l), .xlen64_o(w_l), .fp_on_o(fp_l), .count_o(cnt_l), .irq_pend_o(pd_l)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            retire = 1'b1;
        end
        @(negedge clk);
        retire = 1'b0;
    endtask

    task automatic idle_all;
        stat_we = 1'b0; cnt_we = 1'b0; cmp_we = 1'b0;
        retire = 1'b0; pend_clr_we = 1'b0; pend_clr_mask = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 status full", 64'(st_f), 64'h0000_000C);
        chk("R1 width full", 64'(w_f), 64'd1);
        chk("R1 fp full", 64'(fp_f), 64'd0);
        chk("R1 count", 64'(cnt_f), 64'd0);
        chk("R1 pending", 64'(pd_f), 64'd0);
        chk("R1 status lite", 64'(st_l), 64'h0000_0008);
        chk("R1 width lite", 64'(w_l), 64'd0);

        // R2 R3 R4 R5 table of status writes
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            stat_we = 1'b1;
            stat_wdata = VECS[v].wd;
            @(negedge clk);
            stat_we = 1'b0;
            chk("R2 status full", 64'(st_f), 64'(VECS[v].full_s));
            chk("R5 width full", 64'(w_f), 64'(VECS[v].full_w));
            chk("R4 fp full", 64'(fp_f), 64'(VECS[v].full_f));
            chk("R3 status lite", 64'(st_l), 64'(VECS[v].lite_s));
            chk("R3 width lite", 64'(w_l), 64'(VECS[v].lite_w));
            chk("R4 fp lite", 64'(fp_l), 64'd0);
        end

        // R7 match at zero compare on first retire
        pulse(1);
        chk("R6 count one", 64'(cnt_f), 64'd1);
        chk("R7 hit at zero", 64'(pd_f), 64'h80);

        // R8 sticky across retires
        pulse(5);
        chk("R6 count six", 64'(cnt_f), 64'd6);
        chk("R8 held", 64'(pd_f), 64'h80);

        // R8 clear of non-timer bits leaves it
        @(negedge clk); pend_clr_we = 1'b1; pend_clr_mask = 8'h7F;
        @(negedge clk); idle_all();
        chk("R8 other mask", 64'(pd_f), 64'h80);

        // R8 software clear
        @(negedge clk); pend_clr_we = 1'b1; pend_clr_mask = 8'h80;
        @(negedge clk); idle_all();
        chk("R8 sw clear", 64'(pd_f), 64'h00);

        // counter 10, compare 12
        @(negedge clk); cnt_we = 1'b1; cnt_wdata = 32'd10; cmp_we = 1'b1; cmp_wdata = 32'd12;
        @(negedge clk); idle_all();
        chk("R9 count load", 64'(cnt_f), 64'd10);

        pulse(2);
        chk("R7 no early hit", 64'(pd_f), 64'h00);
        chk("R6 count twelve", 64'(cnt_f), 64'd12);
        pulse(1);
        chk("R7 hit on pre value", 64'(pd_f), 64'h80);
        chk("R6 count thirteen", 64'(cnt_f), 64'd13);

        // R8 compare write clears
        @(negedge clk); cmp_we = 1'b1; cmp_wdata = 32'd100;
        @(negedge clk); idle_all();
        chk("R8 cmp clear", 64'(pd_f), 64'h00);

        // R9 counter write beats retire and blocks the match
        @(negedge clk); cmp_we = 1'b1; cmp_wdata = 32'd13;
        @(negedge clk); cmp_we = 1'b0; cnt_we = 1'b1; cnt_wdata = 32'd50; retire = 1'b1;
        @(negedge clk); idle_all();
        chk("R9 load wins", 64'(cnt_f), 64'd50);
        chk("R9 no hit", 64'(pd_f), 64'h00);

        // R10 match beats clear
        @(negedge clk); cmp_we = 1'b1; cmp_wdata = 32'd50;
        @(negedge clk); cmp_we = 1'b0; retire = 1'b1; pend_clr_we = 1'b1; pend_clr_mask = 8'hFF;
        @(negedge clk); idle_all();
        chk("R10 set wins", 64'(pd_f), 64'h80);
        chk("R6 count 51", 64'(cnt_f), 64'd51);

        // R6 wrap and hold
        @(negedge clk); cnt_we = 1'b1; cnt_wdata = 32'hFFFF_FFFF;
        @(negedge clk); idle_all();
        pulse(1);
        chk("R6 wrap", 64'(cnt_f), 64'd0);
        repeat (3) @(negedge clk);
        chk("R6 hold idle", 64'(cnt_f), 64'd0);
        chk("R6 lite count", 64'(cnt_l), 64'd0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule